// File: doc/BRIEF.md
# SMBus Register Slave with Strapped Address

This block is the serial-bus front end of a register-mapped device. It watches the two bus wires, SCL and SDA, through a synchronizer and glitch filter clocked by the system clock. From the filtered wires it recognises start, repeated start and stop conditions. It takes in an address byte and answers only when that byte carries its own 7-bit address. It drives SDA only by pulling it low, through an output enable.

A write transfer loads a byte pointer from its first data byte. Each later byte leaves as a one-cycle write strobe on a simple register port, at the pointer. A read transfer sends register bytes, taken from the same port at the pointer, until the master declines a byte. The pointer steps after every byte moved, so a pointer write followed by a repeated start and a read gives a burst read from a chosen register.

The upper five address bits are fixed. The lower two come from a three-level board strap, already encoded into two bits. The strap is captured once, at the first start condition after reset, and then stays locked.

Top module: `smb_regslave`

## Requirements
- R1: The device address is 7 bits: the fixed value 01011 on top, then the two locked strap bits A1 (bit 1) and A0 (bit 0). When an address byte (address MSB first, then R/W in bit 0, where 0 = write and 1 = read) matches, the slave pulls SDA low for the whole high phase of the 9th clock.
- R2: Start is SDA falling while SCL is high, and stop is SDA rising while SCL is high. Clocked bits that follow reset or a stop with no start between are ignored, and the slave does not acknowledge them.
- R3: strap_i carries {A1,A0}, with ground encoded as 00, open as 10 and tied high as 01. It is sampled at the first start after reset and held until the next reset. Later strap changes do not alter the address that is answered.
- R4: After a non-matching address the slave does not acknowledge, drives nothing, and writes nothing until the next start.
- R5: In a write transfer the first data byte loads the pointer, which then appears on reg_addr. That byte produces no register write.
- R6: Each further write byte gives exactly one reg_wr pulse of one clock, with reg_addr equal to the pointer and reg_wdata equal to the byte. Every byte written to a selected slave is acknowledged.
- R7: Read bytes are taken from reg_rdata at the pointer and sent MSB first. The slave changes its SDA drive only while SCL is low, and only after SCL has fallen.
- R8: When the master leaves the 9th bit of a read byte high (no acknowledge), the slave stops sending and keeps SDA released.
- R9: The pointer resets to 0. It increments after each byte written at it or read from it, and wraps from 255 to 0.
- R10: A repeated start in place of a stop opens a new address phase at once and keeps the pointer, so a pointer write followed by a read returns data from that pointer.
- R11: A pulse shorter than three system clocks on either wire is removed before condition and edge detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level |
| sda_oe | output | 1 | When 1, the data wire is pulled low |
| strap_i | input | 2 | Encoded address strap {A1,A0} |
| reg_addr | output | 8 | Register pointer |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data at reg_addr |

## Verification
The hardest situation to reach from the ports is a pulse on SDA during an SCL high phase, in the middle of a byte. Left unfiltered, such a pulse would be taken as a false start or stop. The stimulus creates it on purpose: the master model inserts a two-clock pulse on SDA in the high phase of a chosen data bit, low on a 1 bit and high on a 0 bit. The bench then requires the byte to be written intact. Strap locking also needs a sequence of its own: the strap is changed after the first transfer, and the bench confirms that the old address is still answered and the new one is refused.

// File: rtl/smbs_pkg.sv
package smbs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WDAT,
    S_WACK,
    S_RDAT,
    S_RACK
  } smbs_st_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/smbs_filt.sv
module smbs_filt #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   out_q, out_d;

  // output follows only when every sample in the window agrees
  always_comb begin
    out_d = out_q;
    if (&hist_q)       out_d = 1'b1;
    else if (~|hist_q) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      out_q  <= out_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/smbs_cond.sv
module smbs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;
  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
endmodule

// File: rtl/smbs_core.sv
module smbs_core
  import smbs_pkg::*;
#(
  parameter logic [4:0]  ADDR_HI = 5'b01011,
  parameter int unsigned PTR_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_f,
  input  logic [1:0]       strap_i,
  input  logic [BYTE_W-1:0] rdata,
  output logic             oe,
  output logic [PTR_W-1:0] ptr,
  output logic             wr,
  output logic [BYTE_W-1:0] wdata,
  output logic             idle,
  output logic             locked,
  output logic [1:0]       addr_lo
);
  smbs_st_e          st_q, st_d;
  logic [2:0]        bcnt_q, bcnt_d;
  logic              full_q, full_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d, first_q, first_d, inc_q, inc_d, nack_q, nack_d;
  logic              oe_q, oe_d, wr_q, wr_d, lock_q, lock_d;
  logic [1:0]        alo_q, alo_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [BYTE_W-1:0] wd_q, wd_d;

  always_comb begin
    st_d = st_q;  bcnt_d = bcnt_q; full_d = full_q; sh_d = sh_q;
    rw_d = rw_q;  first_d = first_q; inc_d = inc_q; nack_d = nack_q;
    oe_d = oe_q;  wr_d = 1'b0; lock_d = lock_q; alo_d = alo_q;
    ptr_d = ptr_q; wd_d = wd_q;
    if (start_det) begin
      st_d = S_ADDR; bcnt_d = '0; full_d = 1'b0; oe_d = 1'b0;
      if (!lock_q) begin
        lock_d = 1'b1;
        alo_d  = strap_i;
      end
    end else if (stop_det) begin
      st_d = S_IDLE; oe_d = 1'b0;
    end else begin
      unique case (st_q)
        S_ADDR, S_WDAT: begin
          if (scl_rise && !full_q) begin
            sh_d   = {sh_q[BYTE_W-2:0], sda_f};
            bcnt_d = bcnt_q + 3'd1;
            if (bcnt_q == 3'd7) full_d = 1'b1;
          end else if (scl_fall && full_q) begin
            full_d = 1'b0;
            if (st_q == S_ADDR) begin
              if (sh_q[7:1] == {ADDR_HI, alo_q}) begin
                oe_d = 1'b1; rw_d = sh_q[0]; st_d = S_AACK;
              end else begin
                st_d = S_IDLE;
              end
            end else begin
              oe_d = 1'b1; st_d = S_WACK;
              if (first_q) begin
                ptr_d = PTR_W'(sh_q); first_d = 1'b0; inc_d = 1'b0;
              end else begin
                wr_d = 1'b1; wd_d = sh_q; inc_d = 1'b1;
              end
            end
          end
        end
        S_AACK: if (scl_fall) begin
          bcnt_d = '0; full_d = 1'b0;
          if (rw_q) begin
            sh_d = rdata; oe_d = ~rdata[7]; st_d = S_RDAT;
          end else begin
            oe_d = 1'b0; first_d = 1'b1; st_d = S_WDAT;
          end
        end
        S_WACK: if (scl_fall) begin
          oe_d = 1'b0; bcnt_d = '0; st_d = S_WDAT;
          if (inc_q) ptr_d = ptr_q + PTR_W'(1);
        end
        S_RDAT: begin
          if (scl_rise) begin
            bcnt_d = bcnt_q + 3'd1;
            if (bcnt_q == 3'd7) full_d = 1'b1;
          end else if (scl_fall) begin
            if (full_q) begin
              full_d = 1'b0; oe_d = 1'b0; st_d = S_RACK;
              ptr_d  = ptr_q + PTR_W'(1);
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) nack_d = sda_f;
          else if (scl_fall) begin
            if (nack_q) st_d = S_IDLE;
            else begin
              sh_d = rdata; oe_d = ~rdata[7]; bcnt_d = '0; st_d = S_RDAT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; bcnt_q <= '0; full_q <= 1'b0; sh_q <= '0;
      rw_q <= 1'b0; first_q <= 1'b0; inc_q <= 1'b0; nack_q <= 1'b0;
      oe_q <= 1'b0; wr_q <= 1'b0; lock_q <= 1'b0; alo_q <= '0;
      ptr_q <= '0; wd_q <= '0;
    end else begin
      st_q <= st_d; bcnt_q <= bcnt_d; full_q <= full_d; sh_q <= sh_d;
      rw_q <= rw_d; first_q <= first_d; inc_q <= inc_d; nack_q <= nack_d;
      oe_q <= oe_d; wr_q <= wr_d; lock_q <= lock_d; alo_q <= alo_d;
      ptr_q <= ptr_d; wd_q <= wd_d;
    end
  end

  assign oe      = oe_q;
  assign ptr     = ptr_q;
  assign wr      = wr_q;
  assign wdata   = wd_q;
  assign idle    = (st_q == S_IDLE);
  assign locked  = lock_q;
  assign addr_lo = alo_q;
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter logic [4:0]  ADDR_HI     = 5'b01011,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3,
  parameter int unsigned PTR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       strap_i,
  output logic [PTR_W-1:0] reg_addr,
  output logic             reg_wr,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata
);
  localparam int unsigned N_LINES = 2;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [N_LINES-1:0] line_raw, line_f;
  logic               scl_f, sda_f;
  logic               start_det, stop_det, scl_rise, scl_fall;
  logic               core_idle, locked;
  logic [1:0]         addr_lo;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    smbs_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_int_n),
      .din  (line_raw[g]),
      .dout (line_f[g])
    );
  end

  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  smbs_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  smbs_core #(.ADDR_HI(ADDR_HI), .PTR_W(PTR_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_f    (sda_f),
    .strap_i  (strap_i),
    .rdata    (reg_rdata),
    .oe       (sda_oe),
    .ptr      (reg_addr),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .idle     (core_idle),
    .locked   (locked),
    .addr_lo  (addr_lo)
  );
endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       reg_wr,
  input logic       scl_f,
  input logic       start_det,
  input logic       stop_det,
  input logic       core_idle,
  input logic       locked,
  input logic [1:0] addr_lo
);
  // R4: an idle slave never pulls the data wire
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_idle |-> !sda_oe);

  // R6: write strobe is a single clock wide
  p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R7: the drive is taken up only while the filtered clock is low
  p_oe_low_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  // R2: a stop returns the slave to idle
  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> core_idle);

  // R10: a start, repeated or not, opens an address phase
  p_start_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !core_idle);

  // R3: the strap bits never move once locked
  p_lock_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(addr_lo));

  // R3: locking happens only on a start
  p_lock_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(start_det));
endmodule

bind smb_regslave smb_regslave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .sda_oe   (sda_oe),
  .reg_wr   (reg_wr),
  .scl_f    (scl_f),
  .start_det(start_det),
  .stop_det (stop_det),
  .core_idle(core_idle),
  .locked   (locked),
  .addr_lo  (addr_lo)
);

// File: tb/smb_regslave_tb.sv
module smb_regslave_tb;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       sda_oe, reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_line;
  logic [7:0] mem [256];

  int n_cmp = 0, n_bad = 0;
  logic [15:0] wq[$];
  logic [7:0]  exp_mem [256];

  always #4 clk = ~clk;

  assign sda_line  = m_sda & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

  smb_regslave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write monitor: pops expected items as strobes appear
  initial begin
    forever begin
      @(negedge clk);
      if (reg_wr) begin
        if (wq.size() == 0) chk(1'b0, "R6 unexpected write", {reg_addr, reg_wdata}, 16'h0);
        else begin
          logic [15:0] e;
          e = wq.pop_front();
          chk({reg_addr, reg_wdata} == e, "R6 write item", {reg_addr, reg_wdata}, e);
        end
      end
    end
  end

  task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
    wq.push_back({a, d});
    exp_mem[a] = d;
  endtask

  task automatic bitx(input logic b, input bit glitch, output logic rx, output logic rx2);
    m_sda = b; wt(Q);
    m_scl = 1'b1; wt(Q);
    rx = sda_line;
    if (glitch) begin m_sda = ~b; wt(2); m_sda = b; end
    wt(Q);
    rx2 = sda_line;
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic start_c();
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic send(input logic [7:0] b, input int gbit, output logic ack);
    logic r, r2;
    for (int i = 7; i >= 0; i--) bitx(b[i], (i == gbit), r, r2);
    bitx(1'b1, 1'b0, r, r2);
    ack = ~r;
  endtask

  task automatic recv(input logic nack, input logic [7:0] exp);
    logic r, r2;
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      bitx(1'b1, 1'b0, r, r2);
      b[i] = r;
      chk(r == r2, "R7 data held through high phase", {15'h0, r2}, {15'h0, r});
    end
    bitx(nack, 1'b0, r, r2);
    chk(b == exp, "R7 read byte", {8'h0, b}, {8'h0, exp});
  endtask

  logic ack;
  localparam logic [7:0] AW  = 8'h5C;  // 0x2E, write
  localparam logic [7:0] AR  = 8'h5D;  // 0x2E, read
  localparam logic [7:0] AXW = 8'h5A;  // 0x2D, write

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    wt(5); rst_n = 1'b1; wt(10);

    // reset state
    chk(sda_oe == 1'b0, "R1 reset no drive", {15'h0, sda_oe}, 16'h0);
    chk(reg_wr == 1'b0, "R6 reset no strobe", {15'h0, reg_wr}, 16'h0);
    chk(reg_addr == 8'h00, "R9 pointer reset", {8'h0, reg_addr}, 16'h0);

    // R2: clocked address with no start is ignored
    m_scl = 1'b0; wt(Q);
    send(AW, -1, ack);
    chk(ack == 1'b0, "R2 no ack without start", {15'h0, ack}, 16'h0);
    m_scl = 1'b1; m_sda = 1'b1; wt(Q);

    // R1, R5, R6: strap open (10) -> address 0x2E
    start_c();
    send(AW, -1, ack);
    chk(ack, "R1 address ack", {15'h0, ack}, 16'h1);
    send(8'h10, -1, ack);
    chk(ack, "R5 pointer byte ack", {15'h0, ack}, 16'h1);
    wt(4);
    chk(reg_addr == 8'h10, "R5 pointer loaded", {8'h0, reg_addr}, 16'h10);
    push_wr(8'h10, 8'hA1); push_wr(8'h11, 8'hB2);
    send(8'hA1, -1, ack);
    chk(ack, "R6 data ack", {15'h0, ack}, 16'h1);
    send(8'hB2, -1, ack);
    stop_c();
    chk(wq.size() == 0, "R6 writes done", 16'(wq.size()), 16'h0);

    // R2: after stop, bits without start are ignored
    m_scl = 1'b0; wt(Q);
    send(AW, -1, ack);
    chk(ack == 1'b0, "R2 ignored after stop", {15'h0, ack}, 16'h0);
    m_scl = 1'b1; m_sda = 1'b1; wt(Q);

    // R4: other address
    start_c();
    send(AXW, -1, ack);
    chk(ack == 1'b0, "R4 foreign address nack", {15'h0, ack}, 16'h0);
    send(8'h00, -1, ack);
    chk(ack == 1'b0, "R4 stays silent", {15'h0, ack}, 16'h0);
    send(8'h77, -1, ack);
    stop_c();

    // R3: strap change after lock is ignored
    strap = 2'b01;
    start_c();
    send(AW, -1, ack);
    chk(ack, "R3 locked address still answered", {15'h0, ack}, 16'h1);
    stop_c();
    start_c();
    send(AXW, -1, ack);
    chk(ack == 1'b0, "R3 new strap address refused", {15'h0, ack}, 16'h0);
    stop_c();

    // R10, R7, R8: pointer write, repeated start, read
    start_c();
    send(AW, -1, ack);
    send(8'h10, -1, ack);
    start_c();
    send(AR, -1, ack);
    chk(ack, "R10 read address after repeated start", {15'h0, ack}, 16'h1);
    recv(1'b0, exp_mem[8'h10]);
    recv(1'b1, exp_mem[8'h11]);
    wt(Q);
    chk(sda_oe == 1'b0, "R8 released after nack", {15'h0, sda_oe}, 16'h0);
    stop_c();

    // R9: wrap on write and read
    start_c();
    send(AW, -1, ack);
    send(8'hFE, -1, ack);
    push_wr(8'hFE, 8'h01); push_wr(8'hFF, 8'h02); push_wr(8'h00, 8'h03);
    send(8'h01, -1, ack); send(8'h02, -1, ack); send(8'h03, -1, ack);
    stop_c();
    chk(wq.size() == 0, "R9 wrapped writes", 16'(wq.size()), 16'h0);
    start_c();
    send(AW, -1, ack);
    send(8'hFF, -1, ack);
    start_c();
    send(AR, -1, ack);
    recv(1'b0, exp_mem[8'hFF]);
    recv(1'b1, exp_mem[8'h00]);
    stop_c();
    chk(reg_addr == 8'h01, "R9 pointer after wrapped read", {8'h0, reg_addr}, 16'h01);

    // R11: short pulses inside data bits
    start_c();
    send(AW, -1, ack);
    send(8'h40, -1, ack);
    push_wr(8'h40, 8'hFF); push_wr(8'h41, 8'h00);
    send(8'hFF, 3, ack);
    chk(ack, "R11 low pulse not a start", {15'h0, ack}, 16'h1);
    send(8'h00, 5, ack);
    chk(ack, "R11 high pulse not a stop", {15'h0, ack}, 16'h1);
    stop_c();
    wt(10);
    chk(wq.size() == 0, "R11 bytes written intact", 16'(wq.size()), 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule